// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank Array

This block gives software a set of general-purpose I/O banks, each carrying up to 32 lines, behind a plain 32-bit register port. Every line has its own direction, output value and open-drain selection. Inputs are resynchronised to the core clock and watched for trigger events. The trigger type is chosen per line by three configuration registers: an edge polarity, a both-edges override and a level mode. Detected events land in sticky pending bits. Software clears these bits by writing ones to them.

The banks repeat at a stride of eight 32-bit words. All banks drive one shared interrupt output, which is high while any enabled pending bit is set in any bank. The interrupt enables come out of reset cleared, so an event that happened before software set the block up cannot raise the interrupt. The number of banks, the number of live lines per bank and the synchroniser depth are parameters. Lines at or above the live count behave as absent.

Top module: `gpio_irq_banks`

## Requirements
- R1: After reset every direction bit of a live line reads 1 (input), every other register reads 0, pin_oe and pin_out are all zero and irq is low.
- R2: bus_addr is a word address: bank b is selected by bus_addr[ADDR_W-1:3] = b, and bus_addr[2:0] picks the register: 0 open-drain select, 1 data, 2 direction, 3 edge polarity, 4 both-edges, 5 interrupt enable, 6 level mode, 7 pending. Pin index n belongs to bank n/32, bit n%32. bus_rdata is combinational in the same cycle as the address. A write takes effect at the clock edge where bus_wr is high.
- R3: A line whose direction bit is 0 and open-drain bit is 0 drives pin_out from its data bit with pin_oe at 1. A line whose direction bit is 1 has pin_oe at 0 and pin_out at 0. Reading the data register returns the data bit for output lines and the synchronised pin for input lines.
- R4: An output line with its open-drain bit at 1 has pin_out at 0, and pin_oe is 1 only while its data bit is 0.
- R5: With level mode 0 and both-edges 0, a polarity bit of 1 catches rising edges only and 0 catches falling edges only. A pin change presented before clock edge k shows in the pending register after edge k+2.
- R6: With level mode 0 and both-edges 1, both rising and falling edges set the pending bit, whatever the polarity bit holds.
- R7: Level mode 1 overrides the edge settings. A polarity of 0 is active high and 1 is active low. The pending bit is set again on every cycle the active level is present, so a clear has no lasting effect while the level holds.
- R8: Writing the pending register clears the bits written as 1 and leaves the bits written as 0 unchanged. Pending bits never clear on their own. An event in the same cycle as its clear wins.
- R9: irq is high exactly while some bank has a bit set in both its pending and interrupt-enable registers. The enables reset to zero, so a pending bit alone does not raise irq.
- R10: Lines at or above BANK_LINES read 0 in every register, ignore writes, never become pending and keep pin_oe and pin_out at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (4 by default) | Word address: bank index above, register index in the low 3 bits |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pin_in | input | NUM_BANKS*32 | Asynchronous pin levels |
| pin_out | output | NUM_BANKS*32 | Output drive value |
| pin_oe | output | NUM_BANKS*32 | Output drive enable |
| irq | output | 1 | Shared interrupt over all banks |

## Verification
The bench checks that an edge of the polarity that was not selected leaves pending clear; a detector with inverted or ignored polarity would flag it. It clears a level-mode line while its level still holds and expects the bit to return, which catches a design that lets the clear win or treats level as a one-shot edge. It writes zeros to the pending register to show that they do not clear, and it sets a pending bit before enabling it to show that irq stays low until the enable is written. Pin toggles and register writes on lines above the live count must leave every readback zero; a design that does not cut those lines off would show stray pending bits or drive enables there.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
   localparam int unsigned REG_W     = 32;
   localparam int unsigned REG_SEL_W = 3;

   typedef enum logic [REG_SEL_W-1:0] {
      RG_ODRAIN = 3'd0,
      RG_DATA   = 3'd1,
      RG_DIR    = 3'd2,
      RG_EPOL   = 3'd3,
      RG_EANY   = 3'd4,
      RG_MASK   = 3'd5,
      RG_LEVEL  = 3'd6,
      RG_PEND   = 3'd7
   } reg_sel_e;
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic [WIDTH-1:0] q_prev
);
   localparam int unsigned DEPTH = STAGES + 1;

   logic [WIDTH-1:0] pipe [DEPTH];

   initial begin
      AST_SYNC_DEPTH: assert (STAGES >= 2) else $error("STAGES must be at least 2"); // R5
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
      end else begin
         pipe[0] <= d;
         for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
      end
   end

   assign q      = pipe[STAGES-1];
   assign q_prev = pipe[STAGES];
endmodule

// File: rtl/gpb_detect.sv
module gpb_detect #(
   parameter int unsigned LINES = 32
) (
   input  logic [31:0] cur,
   input  logic [31:0] prev,
   input  logic [31:0] epol,
   input  logic [31:0] eany,
   input  logic [31:0] lvl,
   output logic [31:0] evt
);
   logic [31:0] raw;

   for (genvar i = 0; i < 32; i++) begin : g_line
      logic rise, fall;
      assign rise = cur[i] & ~prev[i];
      assign fall = ~cur[i] & prev[i];
      always_comb begin
         if (lvl[i])       raw[i] = cur[i] ^ epol[i];   // R7 level, polarity 1 = active low
         else if (eany[i]) raw[i] = rise | fall;        // R6 both edges
         else if (epol[i]) raw[i] = rise;               // R5 rising
         else              raw[i] = fall;               // R5 falling
      end
   end

   if (LINES >= 32) begin : g_full
      assign evt = raw;
   end else begin : g_part
      localparam logic [31:0] LIVE = (32'd1 << LINES) - 32'd1;
      assign evt = raw & LIVE;                          // R10
   end
endmodule

// File: rtl/gpb_bank.sv
module gpb_bank
   import gpb_pkg::*;
#(
   parameter int unsigned LINES = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  reg_sel_e    sel,
   input  logic [31:0] wdata,
   input  logic [31:0] cur,
   input  logic [31:0] evt,
   output logic [31:0] rdata,
   output logic [31:0] pout,
   output logic [31:0] poe,
   output logic [31:0] epol_o,
   output logic [31:0] eany_o,
   output logic [31:0] lvl_o,
   output logic        irq_o
);
   localparam logic [31:0] LIVE = (LINES >= 32) ? 32'hFFFF_FFFF
                                                : ((32'd1 << LINES) - 32'd1);

   logic [31:0] odr_q, dout_q, dir_q, epol_q, eany_q, mask_q, lvl_q, pend_q;
   logic [31:0] clr, wmask;

   assign wmask = wdata & LIVE;
   assign clr   = (wr_en && sel == RG_PEND) ? wmask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         odr_q  <= '0;
         dout_q <= '0;
         dir_q  <= LIVE;
         epol_q <= '0;
         eany_q <= '0;
         mask_q <= '0;
         lvl_q  <= '0;
         pend_q <= '0;
      end else begin
         if (wr_en) begin
            case (sel)
               RG_ODRAIN: odr_q  <= wmask;
               RG_DATA:   dout_q <= wmask;
               RG_DIR:    dir_q  <= wmask;
               RG_EPOL:   epol_q <= wmask;
               RG_EANY:   eany_q <= wmask;
               RG_MASK:   mask_q <= wmask;
               RG_LEVEL:  lvl_q  <= wmask;
               default:   ;
            endcase
         end
         pend_q <= (pend_q & ~clr) | evt;
      end
   end

   always_comb begin
      case (sel)
         RG_ODRAIN: rdata = odr_q;
         RG_DATA:   rdata = ((dout_q & ~dir_q) | (cur & dir_q)) & LIVE;
         RG_DIR:    rdata = dir_q;
         RG_EPOL:   rdata = epol_q;
         RG_EANY:   rdata = eany_q;
         RG_MASK:   rdata = mask_q;
         RG_LEVEL:  rdata = lvl_q;
         default:   rdata = pend_q;
      endcase
   end

   assign poe    = ~dir_q & LIVE & ~(odr_q & dout_q);
   assign pout   = dout_q & ~odr_q & ~dir_q & LIVE;
   assign epol_o = epol_q;
   assign eany_o = eany_q;
   assign lvl_o  = lvl_q;
   assign irq_o  = |(pend_q & mask_q);

   AST_MASK_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (mask_q == '0)); // R9

   AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(pend_q) & ~$past(clr)) & ~pend_q) == '0)); // R8

   AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(evt) & ~pend_q) == '0)); // R5
endmodule

// File: rtl/gpio_irq_banks.sv
module gpio_irq_banks
   import gpb_pkg::*;
#(
   parameter int unsigned NUM_BANKS   = 2,
   parameter int unsigned BANK_LINES  = 24,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int unsigned ADDR_W     = BANK_IDX_W + REG_SEL_W,
   localparam int unsigned PINS       = NUM_BANKS * REG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [PINS-1:0]   pin_in,
   output logic [PINS-1:0]   pin_out,
   output logic [PINS-1:0]   pin_oe,
   output logic              irq
);
   logic [BANK_IDX_W-1:0] bank_idx;
   reg_sel_e              sel;
   logic [31:0]           rd_arr [NUM_BANKS];
   logic [NUM_BANKS-1:0]  irq_vec;
   logic [PINS-1:0]       evt_all;

   assign bank_idx = bus_addr[ADDR_W-1:REG_SEL_W];
   assign sel      = reg_sel_e'(bus_addr[REG_SEL_W-1:0]);

   initial begin
      AST_CFG_LINES: assert (BANK_LINES >= 1 && BANK_LINES <= 32)
         else $error("BANK_LINES out of range"); // R10
      AST_CFG_BANKS: assert (NUM_BANKS >= 1)
         else $error("NUM_BANKS must be positive"); // R2
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [31:0] cur, prev, epol, eany, lvl, evt;
      logic        wr_en;

      assign wr_en = bus_wr && (bank_idx == BANK_IDX_W'(b));

      gpb_sync #(.WIDTH(32), .STAGES(SYNC_STAGES)) u_sync (
         .clk(clk), .rst_n(rst_n), .d(pin_in[b*32 +: 32]),
         .q(cur), .q_prev(prev));

      gpb_detect #(.LINES(BANK_LINES)) u_det (
         .cur(cur), .prev(prev), .epol(epol), .eany(eany), .lvl(lvl),
         .evt(evt));

      gpb_bank #(.LINES(BANK_LINES)) u_bank (
         .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel),
         .wdata(bus_wdata), .cur(cur), .evt(evt), .rdata(rd_arr[b]),
         .pout(pin_out[b*32 +: 32]), .poe(pin_oe[b*32 +: 32]),
         .epol_o(epol), .eany_o(eany), .lvl_o(lvl), .irq_o(irq_vec[b]));

      assign evt_all[b*32 +: 32] = evt;
   end

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++)
         if (bank_idx == BANK_IDX_W'(b)) bus_rdata = rd_arr[b];
   end

   assign irq = |irq_vec;

   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(bus_wr) || ($past(evt_all) != '0))); // R9
endmodule

// File: tb/tb_gpio_irq_banks.sv
module tb_gpio_irq_banks;
   localparam int NB = 2;
   localparam int AW = 4;
   localparam int NP = NB * 32;

   // register indices within a bank (R2)
   localparam int ODR = 0, DAT = 1, DIR = 2, EPO = 3, EAN = 4, MSK = 5, LVL = 6, PND = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out, pin_oe;
   logic          irq;

   always #4 clk = ~clk;

   gpio_irq_banks #(.NUM_BANKS(NB), .BANK_LINES(24), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

   typedef struct {
      int          kind;   // 0 rdata, 1 pin_out, 2 pin_oe, 3 irq
      logic [63:0] exp;
      string       tag;
   } item_t;

   item_t sb[$];
   event  ev_chk;
   int    n_vec = 0;
   int    n_bad = 0;
   bit    done = 1'b0;

   // monitor: pops expected items and compares with what the design shows
   initial begin
      forever begin
         @(ev_chk);
         while (sb.size() > 0) begin
            item_t       it;
            logic [63:0] act;
            it = sb.pop_front();
            case (it.kind)
               0:       act = {32'h0, bus_rdata};
               1:       act = pin_out;
               2:       act = pin_oe;
               default: act = {63'h0, irq};
            endcase
            n_vec++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   function automatic logic [AW-1:0] ra(input int bank, input int r);
      return AW'(bank * 8 + r);
   endfunction

   task automatic push(input int kind, input logic [63:0] exp, input string tag);
      item_t it;
      it.kind = kind;
      it.exp  = exp;
      it.tag  = tag;
      sb.push_back(it);
      -> ev_chk;
   endtask

   task automatic wr(input int bank, input int r, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = ra(bank, r);
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd_chk(input int bank, input int r, input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_addr = ra(bank, r);
      #1;
      push(0, {32'h0, exp}, tag);
   endtask

   task automatic sig_chk(input int kind, input logic [63:0] exp, input string tag);
      @(negedge clk);
      #1;
      push(kind, exp, tag);
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;

      // R1 reset state
      rd_chk(0, DIR, 32'h00FF_FFFF, "R1 dir reset");
      rd_chk(0, MSK, 32'h0, "R1 mask reset");
      rd_chk(0, PND, 32'h0, "R1 pend reset");
      rd_chk(0, DAT, 32'h0, "R1 data reset");
      sig_chk(2, 64'h0, "R1 pin_oe reset");
      sig_chk(1, 64'h0, "R1 pin_out reset");
      sig_chk(3, 64'h0, "R1 irq reset");

      // R3 outputs and data readback, R10 masked bits of dir
      wr(0, DIR, 32'hFFFF_FF00);
      wr(0, DAT, 32'h0000_00A5);
      rd_chk(0, DIR, 32'h00FF_FF00, "R10 dir upper bits dropped");
      sig_chk(1, 64'h0000_0000_0000_00A5, "R3 pin_out push-pull");
      sig_chk(2, 64'h0000_0000_0000_00FF, "R3 pin_oe outputs");
      rd_chk(0, DAT, 32'h0000_00A5, "R3 data read outputs");
      pin_in[10] = 1'b1;
      tick(3);
      rd_chk(0, DAT, 32'h0000_04A5, "R3 data read input pin");
      rd_chk(0, PND, 32'h0, "R5 rise ignored in falling mode");

      // R2 second bank at word stride 8
      wr(1, DIR, 32'hFFFF_FFFC);
      wr(1, DAT, 32'h0000_0003);
      sig_chk(1, 64'h0000_0003_0000_00A5, "R2 bank1 pin_out");
      sig_chk(2, 64'h0000_0003_0000_00FF, "R2 bank1 pin_oe");
      rd_chk(1, DAT, 32'h3, "R2 bank1 data read");
      rd_chk(0, DAT, 32'h0000_04A5, "R2 bank0 untouched");

      // R4 open drain on lines 0 (data 1) and 1 (data 0)
      wr(0, ODR, 32'h0000_0003);
      sig_chk(1, 64'h0000_0003_0000_00A4, "R4 open-drain pin_out");
      sig_chk(2, 64'h0000_0003_0000_00FE, "R4 open-drain pin_oe");

      // R5 rising on line 12, falling on line 10
      wr(0, EPO, 32'h0000_1000);
      pin_in[12] = 1'b1;
      tick(3);
      rd_chk(0, PND, 32'h0000_1000, "R5 rising edge");
      pin_in[10] = 1'b0;
      tick(3);
      rd_chk(0, PND, 32'h0000_1400, "R5 falling edge");
      // R8 write one to clear, write zero keeps
      wr(0, PND, 32'h0000_0400);
      rd_chk(0, PND, 32'h0000_1000, "R8 clear one bit");
      wr(0, PND, 32'h0);
      rd_chk(0, PND, 32'h0000_1000, "R8 zero write keeps");
      pin_in[12] = 1'b0;
      tick(3);
      rd_chk(0, PND, 32'h0000_1000, "R5 fall ignored in rising mode");
      wr(0, PND, 32'h0000_1000);
      rd_chk(0, PND, 32'h0, "R8 clear last bit");

      // R6 both edges on line 13 (polarity 1 ignored)
      wr(0, EPO, 32'h0000_3000);
      wr(0, EAN, 32'h0000_2000);
      pin_in[13] = 1'b1;
      tick(3);
      rd_chk(0, PND, 32'h0000_2000, "R6 both-edges rise");
      wr(0, PND, 32'h0000_2000);
      pin_in[13] = 1'b0;
      tick(3);
      rd_chk(0, PND, 32'h0000_2000, "R6 both-edges fall");
      wr(0, PND, 32'h0000_2000);

      // R7 level high on line 14
      wr(0, LVL, 32'h0000_4000);
      pin_in[14] = 1'b1;
      tick(3);
      rd_chk(0, PND, 32'h0000_4000, "R7 level high sets");
      wr(0, PND, 32'h0000_4000);
      rd_chk(0, PND, 32'h0000_4000, "R7 clear loses while level holds");
      pin_in[14] = 1'b0;
      tick(3);
      wr(0, PND, 32'h0000_4000);
      rd_chk(0, PND, 32'h0, "R7 clear after level drops");
      // R7 level low on line 15 (pin is low)
      wr(0, EPO, 32'h0000_B000);
      wr(0, LVL, 32'h0000_C000);
      tick(2);
      rd_chk(0, PND, 32'h0000_8000, "R7 level low sets");
      pin_in[15] = 1'b1;
      tick(3);
      wr(0, PND, 32'h0000_8000);
      rd_chk(0, PND, 32'h0, "R7 level low cleared");

      // R9 interrupt gating and combining
      pin_in[14] = 1'b1;
      tick(3);
      rd_chk(0, PND, 32'h0000_4000, "R9 pending present");
      sig_chk(3, 64'h0, "R9 irq low while masked");
      wr(0, MSK, 32'h0000_4000);
      sig_chk(3, 64'h1, "R9 irq after enable");
      wr(0, MSK, 32'h0);
      sig_chk(3, 64'h0, "R9 irq after disable");
      wr(1, LVL, 32'h0000_0001);
      pin_in[32] = 1'b1;
      tick(3);
      sig_chk(3, 64'h0, "R9 bank1 pending masked");
      wr(1, MSK, 32'h0000_0001);
      sig_chk(3, 64'h1, "R9 bank1 drives shared irq");
      wr(1, MSK, 32'h0);
      pin_in[14] = 1'b0;
      tick(3);

      // R10 lines above the live count
      wr(0, LVL, 32'h0);
      wr(0, EAN, 32'hFFFF_FFFF);
      rd_chk(0, EAN, 32'h00FF_FFFF, "R10 both-edges upper bits dropped");
      wr(0, ODR, 32'hFFFF_FFFF);
      rd_chk(0, ODR, 32'h00FF_FFFF, "R10 open-drain upper bits dropped");
      wr(0, ODR, 32'h0);
      wr(0, PND, 32'hFFFF_FFFF);
      rd_chk(0, PND, 32'h0, "R10 pend cleared");
      pin_in[30] = 1'b1;
      pin_in[31] = 1'b1;
      tick(3);
      rd_chk(0, PND, 32'h0, "R10 dead lines never pend");
      pin_in[23] = 1'b1;
      tick(3);
      rd_chk(0, PND, 32'h0080_0000, "R10 last live line pends");
      rd_chk(0, DAT, 32'h0080_80A5, "R10 data read hides dead pins");
      wr(0, DIR, 32'h0);
      sig_chk(2, 64'h0000_0003_00FF_FFFF, "R10 no drive above live count");
      sig_chk(1, 64'h0000_0003_0000_00A5, "R10 pin_out above live count");

      tick(2);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule